// File: doc/BRIEF.md
# Adapter reset, power and status register

This block is the host-visible control and status word of a debug adapter. The host changes output bits with two write addresses. A mask written to the set address turns the selected outputs on. The same mask written to the clear address, four bytes higher, turns them off. The outputs drive the target system reset, the TAP reset, the target power switch, two indicator LEDs and the returned-clock mode enable of the shift engine. Because bits are only ever set or cleared, the host never needs a read-modify-write.

Three conditions are caught in sticky flags:
- the target system reset line seen low,
- a target power dropout,
- a returned-clock timeout reported by the shift engine.

The two pin conditions first pass through a synchroniser. Every flag is a two-state machine with the states `FLG_IDLE` and `FLG_HELD`, and it has three transitions:
- *catch* moves `FLG_IDLE` to `FLG_HELD` when the condition is seen.
- *hold* keeps `FLG_HELD` until the flag is re-armed.
- *drop* moves `FLG_HELD` to `FLG_IDLE` on a re-arm while the condition is absent.

A re-arm while the condition is present leaves the flag in `FLG_HELD`. This lets the host write a re-arm and then read, and learn whether the condition is still there. The two pin flags are re-armed through the set address. The timeout flag is re-armed through the clear address.

A read returns one word that holds the control bits and the flags in their fixed positions.

Top module: `rsc_reg_block`

## Requirements
- R1: After reset, every control output is 0, every flag is 0 and `bus_rdata` reads 0.
- R2: A write to the set address sets each selected control bit and leaves the other control bits unchanged. The control bits are: bit 0 system reset (`srst_o`), bit 1 TAP reset (`trst_o`), bit 3 power switch (`pwr_en_o`), bit 4 LED 0 (`led_o[0]`), bit 5 LED 1 (`led_o[1]`) and bit 8 returned-clock mode (`rclk_mode_o`).
- R3: A write to the clear address (set address + 4) clears each selected control bit and leaves the other control bits unchanged.
- R4: Writes to any other address change no control bit. The bits 2, 9 and 11 to 31 store nothing and always read 0.
- R5: A low level on `srst_pin_n` sets flag bit 6 on the third clock edge after it is sampled. The first two edges pass it through the two-stage synchroniser. The flag then stays 1 until it is re-armed.
- R6: A high level on `pwr_drop_pin` sets flag bit 7 with the same synchroniser delay and the same stickiness as R5.
- R7: A high `rclk_timeout` sets flag bit 10 on the next edge. The input is not synchronised, and the flag is sticky.
- R8: Writing bit 6 or bit 7 to the set address re-arms that flag. After the write edge the flag equals the synchronised condition at that edge, so a present condition wins over the re-arm.
- R9: Writing bit 10 to the clear address re-arms the timeout flag. A timeout that is high in the same cycle keeps the flag at 1.
- R10: Flag bits written to the wrong address have no effect. Bits 6 and 7 written to the clear address, and bit 10 written to the set address, change no flag and no control bit.
- R11: `bus_rdata` always shows the current control bits and flags in the positions of R2, R5, R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address of the write |
| bus_wdata | input | 32 | Write mask |
| bus_rdata | output | 32 | Control and flag word |
| srst_pin_n | input | 1 | Sensed target system reset pin, low when asserted |
| pwr_drop_pin | input | 1 | Power dropout detector pin, high on dropout |
| rclk_timeout | input | 1 | Returned-clock timeout from the shift engine |
| srst_o | output | 1 | Drive target system reset |
| trst_o | output | 1 | Drive TAP reset |
| pwr_en_o | output | 1 | Target power switch on |
| led_o | output | 2 | Indicator LEDs |
| rclk_mode_o | output | 1 | Returned-clock mode enable |

## Verification
The bench builds the block with a set address of 8 (clear address 12) rather than the default 0. This proves that decoding follows the parameter and that writes at address 0 fall into the ignored range. The bench uses the default two synchroniser stages. This exposes the exact three-edge latency of the pin flags, so a re-arm can be placed while a condition is still in flight in the synchroniser. Random pin glitches and timeout pulses mixed with writes to all addresses drive each flag's state machine through catch, hold and drop, including the case where a condition coincides with a re-arm.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int unsigned REG_W  = 32;

    // Control bit positions
    localparam int unsigned B_SRST = 0;
    localparam int unsigned B_TRST = 1;
    localparam int unsigned B_PWR  = 3;
    localparam int unsigned B_LED0 = 4;
    localparam int unsigned B_LED1 = 5;
    localparam int unsigned B_RCLK = 8;

    // Sticky flag positions
    localparam int unsigned B_FSRST = 6;
    localparam int unsigned B_FDROP = 7;
    localparam int unsigned B_FTMO  = 10;

    localparam logic [REG_W-1:0] CTRL_MASK =
        (REG_W'(1) << B_SRST) | (REG_W'(1) << B_TRST) | (REG_W'(1) << B_PWR) |
        (REG_W'(1) << B_LED0) | (REG_W'(1) << B_LED1) | (REG_W'(1) << B_RCLK);

    localparam logic [REG_W-1:0] FLAG_MASK =
        (REG_W'(1) << B_FSRST) | (REG_W'(1) << B_FDROP) | (REG_W'(1) << B_FTMO);

    localparam logic [REG_W-1:0] USED_MASK = CTRL_MASK | FLAG_MASK;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_HELD = 1'b1
    } flag_state_e;

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rsc_sticky_flag.sv
module rsc_sticky_flag
    import rsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic rearm_i,
    output logic flag_o
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    // catch / hold / drop; a present condition wins over a re-arm
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (cond_i) state_d = FLG_HELD;
            FLG_HELD: if (rearm_i && !cond_i) state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLG_HELD);
    end

    // R5, R6, R7: a seen condition always ends in the flag
    a_r5_cond_catches: assert property (@(posedge clk) disable iff (!rst_n)
        cond_i |=> flag_o);
    // R5, R6, R7: the flag survives until re-armed
    a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !rearm_i |=> flag_o);
    // R8, R9: re-arm with the condition gone drops the flag
    a_r8_rearm_drops: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i && !cond_i |=> !flag_o);
endmodule

// File: rtl/rsc_ctrl_bits.sv
module rsc_ctrl_bits #(
    parameter int unsigned          W    = 32,
    parameter logic [W-1:0]         MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    logic unused_wbits;
    assign unused_wbits = ^(wdata_i & ~MASK);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                       q_o[i] <= 1'b0;
                else if (set_we_i && wdata_i[i])  q_o[i] <= 1'b1;
                else if (clr_we_i && wdata_i[i])  q_o[i] <= 1'b0;
            end
        end else begin : g_none
            assign q_o[i] = 1'b0;
        end
    end

    a_r2_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
        set_we_i |=> ((q_o & $past(wdata_i & MASK)) == $past(wdata_i & MASK)));
    a_r3_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i && !set_we_i |=> ((q_o & $past(wdata_i & MASK)) == '0));
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !set_we_i && !clr_we_i |=> $stable(q_o));
endmodule

// File: rtl/rsc_reg_block.sv
module rsc_reg_block
    import rsc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned SET_OFFSET  = 0,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              srst_pin_n,
    input  logic              pwr_drop_pin,
    input  logic              rclk_timeout,
    output logic              srst_o,
    output logic              trst_o,
    output logic              pwr_en_o,
    output logic [1:0]        led_o,
    output logic              rclk_mode_o
);
    localparam int unsigned CLR_OFFSET = SET_OFFSET + 4;
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFFSET);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFFSET);

    logic set_we, clr_we;
    logic [REG_W-1:0] ctrl_q;
    logic srst_seen, drop_seen;
    logic f_srst, f_drop, f_tmo;
    logic unused_wbits;

    assign set_we = bus_wr && (bus_addr == SET_A);
    assign clr_we = bus_wr && (bus_addr == CLR_A);
    assign unused_wbits = ^(bus_wdata & ~USED_MASK);

    rsc_ctrl_bits #(.W(REG_W), .MASK(CTRL_MASK)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .set_we_i(set_we), .clr_we_i(clr_we),
        .wdata_i(bus_wdata), .q_o(ctrl_q)
    );

    rsc_sync #(.STAGES(SYNC_STAGES)) u_sync_srst (
        .clk(clk), .rst_n(rst_n), .d_i(~srst_pin_n), .q_o(srst_seen)
    );
    rsc_sync #(.STAGES(SYNC_STAGES)) u_sync_drop (
        .clk(clk), .rst_n(rst_n), .d_i(pwr_drop_pin), .q_o(drop_seen)
    );

    rsc_sticky_flag u_flag_srst (
        .clk(clk), .rst_n(rst_n), .cond_i(srst_seen),
        .rearm_i(set_we && bus_wdata[B_FSRST]), .flag_o(f_srst)
    );
    rsc_sticky_flag u_flag_drop (
        .clk(clk), .rst_n(rst_n), .cond_i(drop_seen),
        .rearm_i(set_we && bus_wdata[B_FDROP]), .flag_o(f_drop)
    );
    rsc_sticky_flag u_flag_tmo (
        .clk(clk), .rst_n(rst_n), .cond_i(rclk_timeout),
        .rearm_i(clr_we && bus_wdata[B_FTMO]), .flag_o(f_tmo)
    );

    always_comb begin
        bus_rdata          = ctrl_q;
        bus_rdata[B_FSRST] = f_srst;
        bus_rdata[B_FDROP] = f_drop;
        bus_rdata[B_FTMO]  = f_tmo;
    end

    assign srst_o      = ctrl_q[B_SRST];
    assign trst_o      = ctrl_q[B_TRST];
    assign pwr_en_o    = ctrl_q[B_PWR];
    assign led_o       = {ctrl_q[B_LED1], ctrl_q[B_LED0]};
    assign rclk_mode_o = ctrl_q[B_RCLK];

    // R4: writes elsewhere leave every output pin alone
    a_r4_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr != SET_A && bus_addr != CLR_A
        |=> $stable({srst_o, trst_o, pwr_en_o, led_o, rclk_mode_o}));
    // R10: a timeout mask at the set address cannot drop the timeout flag
    a_r10_tmo_wrong_addr: assert property (@(posedge clk) disable iff (!rst_n)
        f_tmo && !clr_we |=> f_tmo);
endmodule

// File: tb/rsc_reg_block_test.sv
module rsc_reg_block_test;
    localparam int CLK_PERIOD = 10;
    localparam int SET_OFF    = 8;
    localparam int CLR_OFF    = SET_OFF + 4;
    localparam int SYNC       = 2;
    localparam logic [31:0] CMASK = 32'h0000_013B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic srst_pin_n = 1'b1;
    logic pwr_drop_pin = 1'b0;
    logic rclk_timeout = 1'b0;
    logic srst_o, trst_o, pwr_en_o, rclk_mode_o;
    logic [1:0] led_o;

    int n_checks = 0;
    int n_fail = 0;

    // bench model
    logic [31:0] m_ctrl = '0;
    logic m_f6 = 0, m_f7 = 0, m_f10 = 0;
    logic [SYNC-1:0] m_ps = '0, m_pd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rsc_reg_block #(.ADDR_W(6), .SET_OFFSET(SET_OFF), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .srst_pin_n(srst_pin_n), .pwr_drop_pin(pwr_drop_pin),
        .rclk_timeout(rclk_timeout), .srst_o(srst_o), .trst_o(trst_o),
        .pwr_en_o(pwr_en_o), .led_o(led_o), .rclk_mode_o(rclk_mode_o)
    );

    function automatic logic [31:0] exp_word();
        logic [31:0] w = m_ctrl;
        w[6] = m_f6; w[7] = m_f7; w[10] = m_f10;
        return w;
    endfunction

    function automatic logic [5:0] exp_pins();
        return {m_ctrl[0], m_ctrl[1], m_ctrl[3], m_ctrl[5], m_ctrl[4], m_ctrl[8]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_model(input string tag);
        chk(tag, bus_rdata, exp_word());
        chk(tag, {26'd0, srst_o, trst_o, pwr_en_o, led_o, rclk_mode_o}, {26'd0, exp_pins()});
    endtask

    task automatic step(input logic wr, input logic [5:0] a, input logic [31:0] d,
                        input logic sn, input logic pd, input logic tmo);
        logic set_w, clr_w;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        srst_pin_n = sn; pwr_drop_pin = pd; rclk_timeout = tmo;
        @(posedge clk);
        set_w = wr && (a == 6'(SET_OFF));
        clr_w = wr && (a == 6'(CLR_OFF));
        m_f6  = (set_w && d[6])  ? m_ps[SYNC-1] : (m_f6  | m_ps[SYNC-1]);
        m_f7  = (set_w && d[7])  ? m_pd[SYNC-1] : (m_f7  | m_pd[SYNC-1]);
        m_f10 = (clr_w && d[10]) ? tmo          : (m_f10 | tmo);
        m_ps = {m_ps[SYNC-2:0], ~sn};
        m_pd = {m_pd[SYNC-2:0], pd};
        if (set_w) m_ctrl = m_ctrl | (d & CMASK);
        if (clr_w) m_ctrl = m_ctrl & ~(d & CMASK);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 6'd0, 32'd0, 1, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        #(CLK_PERIOD * 3 + 2);
        chk("R1 word in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        idle(1);
        chk("R1 word after reset", bus_rdata, 32'h0);
        chk_model("R1 pins after reset");

        step(1, 6'(SET_OFF), 32'h0000_013B, 1, 0, 0);
        chk("R2 set all controls", bus_rdata, 32'h0000_013B);
        chk("R2 pins on", {26'd0, srst_o, trst_o, pwr_en_o, led_o, rclk_mode_o}, 32'h3F);
        step(1, 6'(CLR_OFF), 32'h0000_0009, 1, 0, 0);
        chk("R3 clear reset and power", bus_rdata, 32'h0000_0132);
        chk_model("R3 pins");
        step(1, 6'(SET_OFF), 32'hFFFF_FA04, 1, 0, 0);
        chk("R4 reserved bits store nothing", bus_rdata, 32'h0000_0132);
        step(1, 6'd0, 32'hFFFF_FFFF, 1, 0, 0);
        chk("R4 write to address 0 ignored", bus_rdata, 32'h0000_0132);
        step(1, 6'd20, 32'h0000_013B, 1, 0, 0);
        chk("R4 write to address 20 ignored", bus_rdata, 32'h0000_0132);
        step(1, 6'(CLR_OFF), 32'h0000_0132, 1, 0, 0);

        step(0, 6'd0, 32'd0, 0, 0, 0);
        chk("R5 flag clear after 1 edge", bus_rdata & 32'h40, 32'h0);
        idle(1);
        chk("R5 flag clear after 2 edges", bus_rdata & 32'h40, 32'h0);
        idle(1);
        chk("R5 flag set after 3 edges", bus_rdata, 32'h0000_0040);
        idle(4);
        chk("R5 flag sticky", bus_rdata, 32'h0000_0040);

        step(0, 6'd0, 32'd0, 1, 1, 0);
        idle(2);
        chk("R6 dropout flag set", bus_rdata, 32'h0000_00C0);
        step(0, 6'd0, 32'd0, 1, 0, 1);
        chk("R7 timeout flag set next edge", bus_rdata, 32'h0000_04C0);
        idle(3);
        chk("R7 timeout sticky", bus_rdata, 32'h0000_04C0);

        step(1, 6'(SET_OFF), 32'h0000_0040, 1, 0, 0);
        chk("R8 re-arm idle srst flag drops", bus_rdata, 32'h0000_0480);
        for (int i = 0; i < 3; i++) step(0, 6'd0, 32'd0, 0, 0, 0);
        step(1, 6'(SET_OFF), 32'h0000_0040, 0, 0, 0);
        chk("R8 re-arm while pin held low keeps flag", bus_rdata, 32'h0000_04C0);
        idle(3);
        step(1, 6'(SET_OFF), 32'h0000_00C0, 1, 0, 0);
        chk("R8 re-arm both pin flags", bus_rdata, 32'h0000_0400);

        step(1, 6'(SET_OFF), 32'h0000_0400, 1, 0, 0);
        chk("R10 timeout bit at set address ignored", bus_rdata, 32'h0000_0400);
        step(1, 6'(CLR_OFF), 32'h0000_0400, 1, 0, 1);
        chk("R9 clear with coincident timeout keeps flag", bus_rdata, 32'h0000_0400);
        step(1, 6'(CLR_OFF), 32'h0000_0400, 1, 0, 0);
        chk("R9 clear timeout flag", bus_rdata, 32'h0000_0000);

        step(0, 6'd0, 32'd0, 0, 1, 0);
        idle(3);
        step(1, 6'(CLR_OFF), 32'h0000_00C0, 1, 0, 0);
        chk("R10 pin flags at clear address ignored", bus_rdata, 32'h0000_00C0);
        chk_model("R10 model");

        for (int i = 0; i < 3000; i++) begin
            logic [5:0] a;
            logic [31:0] d;
            int pick = int'($urandom_range(0, 3));
            a = (pick == 0) ? 6'(SET_OFF) : (pick == 1) ? 6'(CLR_OFF) : 6'($urandom_range(0, 63));
            d = $urandom;
            if ($urandom_range(0, 1) == 1) d = d & 32'h0000_05FB;
            step($urandom_range(0, 1) == 1, a, d,
                 $urandom_range(0, 7) != 0, $urandom_range(0, 7) == 0,
                 $urandom_range(0, 15) == 0);
            chk_model("R11 random word and pins");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule